// File: doc/BRIEF.md
# LED Blink and Gradation Sequencer

This block is the timing engine behind nine LED current channels. Every channel carries an 8-bit control word: the top two bits choose how the channel behaves (steady, blinking, ramping, or used as an open-drain general-purpose output) and the low six bits hold a linear brightness code. The block turns these words into an effective 6-bit drive code per channel, which a downstream current DAC consumes. A shared 4-bit timing word picks the blink on-time and period and the gradation ramp time. A global direction bit steers ramps up or down.

An external enable pin can take over a preselected set of channels. It is synchronized by two flops. While it is low, the selected channels are dark. While it is high, they follow their normal behaviour. Ramping channels under pin control ramp up after the pin rises and down to zero after it falls, and the global direction bit does not apply to them. The block also emits a one-cycle mode-reset pulse to the supply-mode logic when a blink period ends and when a downward ramp arrives at zero.

All durations are counted in ticks of a single-cycle timebase strobe. The tick counts are parameters, so short values can be used in simulation.

Top module: `ledseq_top`

## Requirements
- R1: After reset, with every control word zero, all drive codes, all open-drain pulls and the mode-reset output are 0.
- R2: A channel whose brightness code (bits 5:0) is 0 drives code 0 and does not pull its open-drain output, whatever its mode.
- R3: Mode 00 (bits 7:6) drives the programmed brightness code continuously.
- R4: Mode 01 drives the code while a shared free-running blink counter is below the on-time, and 0 otherwise. The counter advances on each tick and wraps at the period. Timing bits 3:2 select the pair: 00 long on and short period, 01 short on and short period, 10 long on and long period, 11 short on and long period.
- R5: The mode-reset output is high for one cycle, in the cycle after the tick that closes a blink period, when at least one channel is in mode 01 with a nonzero code.
- R6: Mode 10 with ramp select (timing bits 1:0) at 00 jumps to its target on the next tick. The target is the code when the direction input is 1 and 0 when it is 0.
- R7: Mode 10 with ramp select 01, 10 or 11 (ramp times T1, T2, T3) moves the drive code one unit toward its target every floor(T/code) ticks, with a minimum of 1 tick, and holds it once the target is reached.
- R8: When a downward ramp steps from 1 to 0, the mode-reset output is high for one cycle in the following cycle.
- R9: Mode 11 drives code 0 and asserts the channel's open-drain pull while the code is nonzero. A channel in this mode neither blinks, ramps nor causes a mode reset.
- R10: A channel whose pin-select bit is set, and which is not in mode 10, is dark while the synchronized pin is low. The pin is taken through two flops, so a change appears at the outputs after the second rising clock edge.
- R11: A pin-selected channel in mode 10 ramps toward its code while the synchronized pin is high and toward 0 while it is low, and ignores the direction input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle timebase strobe |
| chanCtrl | input | NCH*8 | Per-channel control words, channel i at bits 8i+7:8i |
| timingSel | input | 4 | Blink select [3:2], ramp select [1:0] |
| rampUp | input | 1 | Ramp direction for channels not under pin control |
| pinSel | input | NCH | Channels controlled by the external pin |
| extPin | input | 1 | External enable pin (asynchronous) |
| driveCode | output | NCH*6 | Effective drive code, channel i at bits 6i+5:6i |
| gpoPull | output | NCH | Open-drain pull request per channel |
| modeReset | output | 1 | One-cycle request to return the supply to its lowest mode |

## Verification
The bench builds the block with short timings: blink on-times of 10 and 3 ticks, periods of 20 and 40, and ramp times of 24, 48 and 96 ticks. With these values whole blink periods, complete up and down ramps and the floor division of ramp time by code can all be observed within a few hundred cycles. Directed runs with a tick on every cycle give exact counts of on-cycles and mode-reset pulses. Random phases that tick on about one cycle in three mix control words, timing selections, pin masks and pin toggles, including codes whose step intervals divide unevenly.

// File: rtl/ledseq_pkg.sv
package ledseq_pkg;
  parameter int TM_W = 16;

  typedef enum logic [1:0] {
    MODE_STEADY = 2'b00,
    MODE_BLINK  = 2'b01,
    MODE_RAMP   = 2'b10,
    MODE_GPO    = 2'b11
  } chanMode_e;

  typedef struct packed {
    logic            tick;
    logic            blinkOn;
    logic            blinkWrap;
    logic            pinLevel;
    logic            rampOff;
    logic [TM_W-1:0] rampTicks;
  } seqStrobe_t;
endpackage

// File: rtl/ledseq_ctrl.sv
module ledseq_ctrl
  import ledseq_pkg::*;
#(
  parameter int BLINK_ON_LONG   = 625,
  parameter int BLINK_ON_SHORT  = 156,
  parameter int BLINK_PER_SHORT = 1250,
  parameter int BLINK_PER_LONG  = 2500,
  parameter int RAMP_T1         = 240,
  parameter int RAMP_T2         = 480,
  parameter int RAMP_T3         = 960
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [3:0] timingSel,
  input  logic       extPin,
  output seqStrobe_t strobe
);
  localparam logic [TM_W-1:0] ON_L  = TM_W'(BLINK_ON_LONG);
  localparam logic [TM_W-1:0] ON_S  = TM_W'(BLINK_ON_SHORT);
  localparam logic [TM_W-1:0] PER_S = TM_W'(BLINK_PER_SHORT);
  localparam logic [TM_W-1:0] PER_L = TM_W'(BLINK_PER_LONG);

  logic [1:0]      syncQ;
  logic [TM_W-1:0] blinkCnt;
  logic [TM_W-1:0] onTicks;
  logic [TM_W-1:0] perTicks;
  logic            wrapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[0], extPin};
  end

  assign onTicks  = timingSel[2] ? ON_S  : ON_L;
  assign perTicks = timingSel[3] ? PER_L : PER_S;
  assign wrapNow  = tick && (blinkCnt >= perTicks - TM_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        blinkCnt <= '0;
    else if (wrapNow) blinkCnt <= '0;
    else if (tick)    blinkCnt <= blinkCnt + TM_W'(1);
  end

  always_comb begin
    strobe.tick      = tick;
    strobe.blinkOn   = blinkCnt < onTicks;
    strobe.blinkWrap = wrapNow;
    strobe.pinLevel  = syncQ[1];
    strobe.rampOff   = (timingSel[1:0] == 2'b00);
    case (timingSel[1:0])
      2'b10:   strobe.rampTicks = TM_W'(RAMP_T2);
      2'b11:   strobe.rampTicks = TM_W'(RAMP_T3);
      default: strobe.rampTicks = TM_W'(RAMP_T1);
    endcase
  end
endmodule

// File: rtl/ledseq_datapath.sv
module ledseq_datapath
  import ledseq_pkg::*;
#(
  parameter int NCH    = 9,
  parameter int CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [NCH*(CODE_W+2)-1:0] chanCtrl,
  input  logic                     rampUp,
  input  logic [NCH-1:0]           pinSel,
  output logic [NCH*CODE_W-1:0]    driveCode,
  output logic [NCH-1:0]           gpoPull,
  output logic                     modeReset
);
  localparam int CTRL_W = CODE_W + 2;

  logic [NCH-1:0] doneVec;
  logic [NCH-1:0] blinkVec;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    chanMode_e       mode;
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] lvl;
    logic [CODE_W-1:0] target;
    logic [TM_W-1:0]   stCnt;
    logic [TM_W-1:0]   quot;
    logic [TM_W-1:0]   interval;
    logic              codeOn;
    logic              isRamp;
    logic              goUp;
    logic              stepNow;
    logic              gated;

    assign mode   = chanMode_e'(chanCtrl[i*CTRL_W+CTRL_W-1 -: 2]);
    assign code   = chanCtrl[i*CTRL_W +: CODE_W];
    assign codeOn = (code != '0);
    assign isRamp = (mode == MODE_RAMP);
    assign gated  = pinSel[i] && !strobe.pinLevel;

    always_comb begin
      if (pinSel[i]) target = strobe.pinLevel ? code : '0;
      else           target = rampUp ? code : '0;
    end

    assign quot     = codeOn ? strobe.rampTicks / {{(TM_W-CODE_W){1'b0}}, code} : strobe.rampTicks;
    assign interval = (quot == '0) ? TM_W'(1) : quot;
    assign goUp     = target > lvl;
    assign stepNow  = strobe.tick && isRamp && codeOn && !strobe.rampOff &&
                      (lvl != target) && (stCnt >= interval - TM_W'(1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvl   <= '0;
        stCnt <= '0;
      end else if (strobe.tick) begin
        if (!isRamp || !codeOn) begin
          lvl   <= '0;
          stCnt <= '0;
        end else if (strobe.rampOff) begin
          lvl   <= target;
          stCnt <= '0;
        end else if (lvl == target) begin
          stCnt <= '0;
        end else if (stepNow) begin
          stCnt <= '0;
          lvl   <= goUp ? lvl + CODE_W'(1) : lvl - CODE_W'(1);
        end else begin
          stCnt <= stCnt + TM_W'(1);
        end
      end
    end

    assign doneVec[i]  = stepNow && !goUp && (lvl == CODE_W'(1));
    assign blinkVec[i] = (mode == MODE_BLINK) && codeOn;

    always_comb begin
      driveCode[i*CODE_W +: CODE_W] = '0;
      gpoPull[i] = 1'b0;
      if (codeOn) begin
        case (mode)
          MODE_STEADY: if (!gated) driveCode[i*CODE_W +: CODE_W] = code;
          MODE_BLINK:  if (!gated && strobe.blinkOn) driveCode[i*CODE_W +: CODE_W] = code;
          MODE_RAMP:   driveCode[i*CODE_W +: CODE_W] = lvl;
          default:     gpoPull[i] = !gated;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReset <= 1'b0;
    else       modeReset <= (strobe.blinkWrap && (|blinkVec)) || (|doneVec);
  end
endmodule

// File: rtl/ledseq_top.sv
module ledseq_top
  import ledseq_pkg::*;
#(
  parameter int NCH             = 9,
  parameter int CODE_W          = 6,
  parameter int BLINK_ON_LONG   = 625,
  parameter int BLINK_ON_SHORT  = 156,
  parameter int BLINK_PER_SHORT = 1250,
  parameter int BLINK_PER_LONG  = 2500,
  parameter int RAMP_T1         = 240,
  parameter int RAMP_T2         = 480,
  parameter int RAMP_T3         = 960
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tick,
  input  logic [NCH*(CODE_W+2)-1:0] chanCtrl,
  input  logic [3:0]                timingSel,
  input  logic                      rampUp,
  input  logic [NCH-1:0]            pinSel,
  input  logic                      extPin,
  output logic [NCH*CODE_W-1:0]     driveCode,
  output logic [NCH-1:0]            gpoPull,
  output logic                      modeReset
);
  seqStrobe_t strobe;

  ledseq_ctrl #(
    .BLINK_ON_LONG(BLINK_ON_LONG), .BLINK_ON_SHORT(BLINK_ON_SHORT),
    .BLINK_PER_SHORT(BLINK_PER_SHORT), .BLINK_PER_LONG(BLINK_PER_LONG),
    .RAMP_T1(RAMP_T1), .RAMP_T2(RAMP_T2), .RAMP_T3(RAMP_T3)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .timingSel(timingSel),
    .extPin(extPin), .strobe(strobe)
  );

  ledseq_datapath #(.NCH(NCH), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanCtrl(chanCtrl),
    .rampUp(rampUp), .pinSel(pinSel), .driveCode(driveCode),
    .gpoPull(gpoPull), .modeReset(modeReset)
  );
endmodule

// File: rtl/ledseq_chk.sv
module ledseq_chk #(
  parameter int NCH    = 9,
  parameter int CODE_W = 6
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      tick,
  input logic [NCH*(CODE_W+2)-1:0] chanCtrl,
  input logic [3:0]                timingSel,
  input logic [NCH*CODE_W-1:0]     driveCode,
  input logic [NCH-1:0]            gpoPull,
  input logic                      modeReset
);
  localparam int CTRL_W = CODE_W + 2;

  // R5 and R8: every mode-reset pulse follows a tick
  p_pulse_after_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    modeReset |-> $past(tick));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic [1:0]        mode;
    logic [CODE_W-1:0] code;
    logic [CODE_W:0]   drv;
    assign mode = chanCtrl[i*CTRL_W+CTRL_W-1 -: 2];
    assign code = chanCtrl[i*CTRL_W +: CODE_W];
    assign drv  = {1'b0, driveCode[i*CODE_W +: CODE_W]};

    p_zero_code_r2: assert property (@(posedge clk) disable iff (!rstN)
      (code == '0) |-> (drv == '0 && !gpoPull[i]));

    p_gpo_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
      (mode == 2'b11) |-> (drv == '0));

    p_nonramp_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
      (mode != 2'b10) |-> (drv <= {1'b0, code}));

    p_ramp_unit_step_r7: assert property (@(posedge clk) disable iff (!rstN)
      (mode == 2'b10 && $past(mode) == 2'b10 && $stable(code) &&
       timingSel[1:0] != 2'b00 && $stable(timingSel))
      |-> (drv + 1'b1 >= $past(drv) && $past(drv) + 1'b1 >= drv));
  end
endmodule

bind ledseq_top ledseq_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .chanCtrl(chanCtrl),
  .timingSel(timingSel), .driveCode(driveCode), .gpoPull(gpoPull),
  .modeReset(modeReset)
);

// File: tb/tb_ledseq_top.sv
module tb_ledseq_top;
  localparam int NCH = 9;
  localparam int CW  = 6;
  localparam int ON_L = 10, ON_S = 3, PER_S = 20, PER_L = 40;
  localparam int RT1 = 24, RT2 = 48, RT3 = 96;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic              tick;
  logic [NCH*8-1:0]  chanCtrl;
  logic [3:0]        timingSel;
  logic              rampUp;
  logic [NCH-1:0]    pinSel;
  logic              extPin;
  logic [NCH*CW-1:0] driveCode;
  logic [NCH-1:0]    gpoPull;
  logic              modeReset;

  ledseq_top #(
    .NCH(NCH), .CODE_W(CW), .BLINK_ON_LONG(ON_L), .BLINK_ON_SHORT(ON_S),
    .BLINK_PER_SHORT(PER_S), .BLINK_PER_LONG(PER_L),
    .RAMP_T1(RT1), .RAMP_T2(RT2), .RAMP_T3(RT3)
  ) dut (.*);

  int errs = 0;
  int checks = 0;
  int s1m, s2m, bcm;
  int lvlm[NCH];
  int stm[NCH];
  int mrm;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int modeOf(int i); return int'(chanCtrl[i*8+6 +: 2]); endfunction
  function automatic int codeOf(int i); return int'(chanCtrl[i*8 +: 6]); endfunction
  function automatic int drvOf(int i); return int'(driveCode[i*CW +: CW]); endfunction
  function automatic int onOf(); return timingSel[2] ? ON_S : ON_L; endfunction
  function automatic int perOf(); return timingSel[3] ? PER_L : PER_S; endfunction
  function automatic int rtOf();
    case (timingSel[1:0])
      2'd2: return RT2;
      2'd3: return RT3;
      default: return RT1;
    endcase
  endfunction

  function automatic int expDrive(int i);
    int m = modeOf(i);
    int c = codeOf(i);
    bit gated = pinSel[i] && (s2m == 0);
    if (c == 0 || m == 3) return 0;
    if (m == 2) return lvlm[i];
    if (gated) return 0;
    if (m == 0) return c;
    return (bcm < onOf()) ? c : 0;
  endfunction

  function automatic int expPull(int i);
    return (modeOf(i) == 3 && codeOf(i) != 0 && !(pinSel[i] && s2m == 0)) ? 1 : 0;
  endfunction

  function automatic string tagOf(int i);
    int m = modeOf(i);
    if (codeOf(i) == 0) return "R2";
    if (m == 2) return pinSel[i] ? "R11" : "R7";
    if (m == 3) return "R9";
    if (pinSel[i]) return "R10";
    return (m == 1) ? "R4" : "R3";
  endfunction

  // one clock: compute reference next state, cross the edge, compare at the falling edge
  task automatic step();
    int ns1, ns2, nbc, nmr;
    int nlvl[NCH];
    int nst[NCH];
    bit wrap, anyBlink, anyDone;
    ns1 = int'(extPin);
    ns2 = s1m;
    wrap = tick && (bcm >= perOf() - 1);
    nbc = wrap ? 0 : (tick ? bcm + 1 : bcm);
    anyBlink = 0;
    anyDone = 0;
    for (int i = 0; i < NCH; i++) begin
      int m = modeOf(i);
      int c = codeOf(i);
      int tgt;
      int iv;
      nlvl[i] = lvlm[i];
      nst[i] = stm[i];
      if (m == 1 && c != 0) anyBlink = 1;
      if (pinSel[i]) tgt = (s2m != 0) ? c : 0;
      else           tgt = rampUp ? c : 0;
      if (tick) begin
        if (m != 2 || c == 0) begin nlvl[i] = 0; nst[i] = 0; end
        else if (timingSel[1:0] == 2'd0) begin nlvl[i] = tgt; nst[i] = 0; end
        else if (lvlm[i] == tgt) nst[i] = 0;
        else begin
          iv = rtOf() / c;
          if (iv < 1) iv = 1;
          if (stm[i] >= iv - 1) begin
            nst[i] = 0;
            if (tgt > lvlm[i]) nlvl[i] = lvlm[i] + 1;
            else begin
              nlvl[i] = lvlm[i] - 1;
              if (lvlm[i] == 1) anyDone = 1;
            end
          end else nst[i] = stm[i] + 1;
        end
      end
    end
    nmr = ((wrap && anyBlink) || anyDone) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    s1m = ns1; s2m = ns2; bcm = nbc; mrm = nmr;
    for (int i = 0; i < NCH; i++) begin lvlm[i] = nlvl[i]; stm[i] = nst[i]; end
    for (int i = 0; i < NCH; i++)
      chk($sformatf("%s ch%0d drive+pull", tagOf(i), i),
          drvOf(i) + 64 * int'(gpoPull[i]), expDrive(i) + 64 * expPull(i));
    chk("R5 R8 modeReset", int'(modeReset), mrm);
  endtask

  function automatic logic [7:0] cw(int m, int c);
    return {m[1:0], c[5:0]};
  endfunction

  initial begin
    #(200000 * 10);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int cnt;
    int onCnt;
    void'($urandom(32'd4242));
    rstN = 1'b0; tick = 1'b0; chanCtrl = '0; timingSel = 4'b0000;
    rampUp = 1'b0; pinSel = '0; extPin = 1'b0;
    s1m = 0; s2m = 0; bcm = 0; mrm = 0;
    for (int i = 0; i < NCH; i++) begin lvlm[i] = 0; stm[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < NCH; i++) chk("R1 drive in reset", drvOf(i), 0);
    chk("R1 pulls in reset", int'(gpoPull), 0);
    chk("R1 modeReset in reset", int'(modeReset), 0);
    rstN = 1'b1;
    step();
    chk("R1 modeReset after reset", int'(modeReset), 0);

    // R7: up ramp, code 8 over 24 ticks -> one step every 3 ticks
    tick = 1'b1; rampUp = 1'b1; timingSel = 4'b0001;
    chanCtrl[0 +: 8] = cw(2, 8);
    repeat (3) step();
    chk("R7 first step after 3 ticks", drvOf(0), 1);
    repeat (21) step();
    chk("R7 ramp reaches code after 24 ticks", drvOf(0), 8);
    step();
    chk("R7 holds at target", drvOf(0), 8);

    // R8: down ramp, one mode-reset pulse at the end
    rampUp = 1'b0;
    cnt = 0;
    repeat (30) begin step(); cnt += int'(modeReset); end
    chk("R8 down ramp at zero", drvOf(0), 0);
    chk("R8 single mode-reset pulse", cnt, 1);

    // R6: ramp disabled jumps to target on next tick
    timingSel = 4'b0000; rampUp = 1'b1;
    step();
    chk("R6 jump to code", drvOf(0), 8);
    rampUp = 1'b0;
    step();
    chk("R6 jump to zero", drvOf(0), 0);
    chanCtrl = '0;

    // R4/R5: short on (3) in short period (20), 40 ticks
    timingSel = 4'b0100;
    chanCtrl[8 +: 8] = cw(1, 20);
    step();
    cnt = 0; onCnt = 0;
    repeat (40) begin
      step();
      cnt += int'(modeReset);
      onCnt += (drvOf(1) == 20) ? 1 : 0;
    end
    chk("R5 blink period pulses in 40 ticks", cnt, 2);
    chk("R4 blink on-cycles in 40 ticks", onCnt, 6);
    timingSel = 4'b1000;
    cnt = 0; onCnt = 0;
    step();
    repeat (80) begin
      step();
      cnt += int'(modeReset);
      onCnt += (drvOf(1) == 20) ? 1 : 0;
    end
    chk("R5 long period pulses in 80 ticks", cnt, 2);
    chk("R4 long on-cycles in 80 ticks", onCnt, 20);
    chanCtrl = '0;
    timingSel = 4'b0000;

    // R9: open-drain mode
    chanCtrl[16 +: 8] = cw(3, 5);
    step();
    chk("R9 gpo drive zero", drvOf(2), 0);
    chk("R9 gpo pull", int'(gpoPull[2]), 1);
    cnt = 0;
    repeat (25) begin step(); cnt += int'(modeReset); end
    chk("R9 no mode reset from gpo", cnt, 0);
    chanCtrl = '0;

    // R10: pin-gated steady channel, two-flop latency
    pinSel = 9'b0_0000_1000;
    chanCtrl[24 +: 8] = cw(0, 7);
    extPin = 1'b0;
    repeat (3) step();
    chk("R10 dark while pin low", drvOf(3), 0);
    extPin = 1'b1;
    step();
    chk("R10 one edge after pin rise", drvOf(3), 0);
    step();
    chk("R10 on after two edges", drvOf(3), 7);
    extPin = 1'b0;
    repeat (2) step();
    chk("R10 off after pin fall", drvOf(3), 0);
    chanCtrl = '0;

    // R11: pin-controlled ramp ignores direction bit
    pinSel = 9'b0_0001_0000;
    chanCtrl[32 +: 8] = cw(2, 4);
    timingSel = 4'b0001; rampUp = 1'b0;
    extPin = 1'b1;
    repeat (30) step();
    chk("R11 ramps up with pin high", drvOf(4), 4);
    extPin = 1'b0; rampUp = 1'b1;
    cnt = 0;
    repeat (30) begin step(); cnt += int'(modeReset); end
    chk("R11 ramps down with pin low", drvOf(4), 0);
    chk("R8 pulse after pin ramp down", cnt, 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if (n % 60 == 0) begin
        for (int i = 0; i < NCH; i++) chanCtrl[i*8 +: 8] = 8'($urandom_range(0, 255));
        timingSel = 4'($urandom_range(0, 15));
        pinSel = 9'($urandom_range(0, 511));
        rampUp = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 40) == 0) extPin = ~extPin;
      if ($urandom_range(0, 80) == 0) rampUp = ~rampUp;
      tick = ($urandom_range(0, 2) == 0);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule